// File: doc/BRIEF.md
# Supply-Guarded Byte Memory

This block is a 2048 x 8 static memory behind an enable-driven control interface: an active-low select, an active-low write strobe and an active-low output strobe. All of these, together with the address, the write data and two status inputs, are sampled on a fast system clock. The bidirectional data pins are split into a write-data input, a read-data output and an output-drive qualifier. A chip-level pad ring combines these into the real bus.

An external comparator supplies a supply-good level. While that level is low, the block ignores every request, stops driving data and leaves the array untouched. When the level returns, the block samples a battery-low status and stays unreachable for a fixed recovery interval. If the battery was reported low at that moment, the block silently discards the first write that completes afterwards. The flag then clears and later writes land normally. The array has no reset, so its contents survive supply-fail periods.

Top module: `pfram_top`

## Requirements
- R1: During reset and afterwards, until the supply-good input has been seen high and the recovery interval has passed, `dout_en` stays low and no access is recognised.
- R2: With `ce_n` sampled high, `dout_en` is low and no write takes place, whatever `we_n` and `oe_n` do.
- R3: With `ce_n` low, `we_n` high and `oe_n` low, `dout_en` is high and `dout` shows the byte stored at `addr`, two clock edges after the inputs are sampled. With `oe_n` high in the same state, `dout_en` stays low.
- R4: A write window is open while both `ce_n` and `we_n` are low, whatever `oe_n` is. The window may close by either enable rising. At the first sampled cycle after closing, the address and data from the last open cycle are stored.
- R5: Whenever `we_n` is sampled low, `dout_en` is low on the next cycle, even if it was driving before.
- R6: While `supply_ok` is low, `dout_en` is low, requests are ignored and no location changes.
- R7: After `supply_ok` rises, requests are ignored for `REC_CYCLES` cycles. A write attempted in that interval leaves the array unchanged.
- R8: `batt_low` is sampled in the cycle the supply returns. If it is high, the first write that completes after recovery is discarded. The flag then clears and the next write is stored.
- R9: Array contents are kept across a supply-fail period.
- R10: `batt_low` is ignored at all other times. A high level while the block is operating does not discard any write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Active-low select |
| we_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low output strobe |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data, zero when not driving |
| dout_en | output | 1 | High while read data should be driven onto the bus |
| supply_ok | input | 1 | Supply within tolerance, from an external comparator |
| batt_low | input | 1 | Battery status, high when low |

## Verification
The bench closes write windows both ways, by lifting the write strobe first and by lifting the select first. A design that commits on the wrong edge, or only handles one of the two orders, stores nothing or stores the wrong byte. It drops the write strobe while a read is already driving and checks that the drive is released. It also checks that the byte written in that window appears afterwards; a design that kept driving would collide with the writer on the bus. Writes are attempted during supply loss and during recovery, and addresses are re-read after power returns. This catches a design that lets an early access through or one that clears its storage. The battery flag is tested with a low report at supply return, where exactly one write must vanish and the next must land. It is also tested with a low report during normal operation, where nothing may vanish.

// File: rtl/pfram_pkg.sv
package pfram_pkg;

    typedef enum logic [1:0] {
        PWR_OFF     = 2'd0,
        PWR_RECOVER = 2'd1,
        PWR_ON      = 2'd2
    } pwr_state_e;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
        logic sup_ok;
        logic batt_low;
    } ctl_t;

    localparam ctl_t CTL_IDLE = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1,
                                  sup_ok: 1'b0, batt_low: 1'b0};

endpackage

// File: rtl/pfram_supply_guard.sv
module pfram_supply_guard
    import pfram_pkg::*;
#(
    parameter int REC_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sup_ok,
    input  logic batt_low,
    input  logic wr_attempt,
    output logic access_ok,
    output logic block_wr
);
    localparam int CNT_W = $clog2(REC_CYCLES + 1);

    typedef struct packed {
        pwr_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic             flag;
    } guard_t;

    guard_t g_d, g_q;

    always_comb begin
        g_d = g_q;
        unique case (g_q.state)
            PWR_OFF: begin
                if (sup_ok) begin
                    g_d.state = PWR_RECOVER;
                    g_d.cnt   = CNT_W'(REC_CYCLES - 1);
                    g_d.flag  = batt_low;
                end
            end
            PWR_RECOVER: begin
                if (!sup_ok)            g_d.state = PWR_OFF;
                else if (g_q.cnt == '0) g_d.state = PWR_ON;
                else                    g_d.cnt   = g_q.cnt - 1'b1;
            end
            PWR_ON: begin
                if (!sup_ok)         g_d.state = PWR_OFF;
                else if (wr_attempt) g_d.flag  = 1'b0;
            end
            default: g_d.state = PWR_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q <= '{state: PWR_OFF, cnt: '0, flag: 1'b0};
        end else begin
            g_q <= g_d;
        end
    end

    assign access_ok = (g_q.state == PWR_ON) && sup_ok;
    assign block_wr  = g_q.flag;

    // R10: the flag can only become set on the way out of the off state
    p_flag_arms_on_return_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(g_q.flag) |-> $past(g_q.state) == PWR_OFF);

    // R8: one swallowed write clears the flag
    p_flag_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (access_ok && g_q.flag && wr_attempt) |=> !g_q.flag);

endmodule

// File: rtl/pfram_access_ctrl.sv
module pfram_access_ctrl #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    input  logic              access_ok,
    input  logic              block_wr,
    output logic              wr_attempt,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              dout_en
);
    typedef struct packed {
        logic              win;
        logic [ADDR_W-1:0] waddr;
        logic [DATA_W-1:0] wdata;
        logic              drive;
    } ctrl_t;

    ctrl_t c_d, c_q;
    logic  win_now;

    always_comb begin
        c_d     = c_q;
        win_now = access_ok && !ce_n && !we_n;
        c_d.win = win_now;
        if (win_now) begin
            c_d.waddr = addr;
            c_d.wdata = data;
        end
        c_d.drive  = access_ok && !ce_n && we_n && !oe_n;
        wr_attempt = c_q.win && !win_now && access_ok;
        wr_en      = wr_attempt && !block_wr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign wr_addr = c_q.waddr;
    assign wr_data = c_q.wdata;
    assign dout_en = c_q.drive;

    // R2: a deselected cycle never drives on the next one
    p_deselect_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> !dout_en);

    // R5: a low write strobe releases the data drive
    p_no_drive_in_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |=> !dout_en);

endmodule

// File: rtl/pfram_array.sv
module pfram_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rd_q;

    // no reset on purpose: contents model battery retention
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
        rd_q <= mem[rd_addr];
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/pfram_top.sv
module pfram_top
    import pfram_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int DATA_W     = 8,
    parameter int REC_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    input  logic              supply_ok,
    input  logic              batt_low
);
    typedef struct packed {
        ctl_t              ctl;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } smp_t;

    smp_t smp_d, smp_q;

    logic              access_ok;
    logic              block_wr;
    logic              wr_attempt;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_data;
    logic              drive;

    always_comb begin
        smp_d = '{ctl: '{ce_n: ce_n, we_n: we_n, oe_n: oe_n,
                         sup_ok: supply_ok, batt_low: batt_low},
                  addr: addr, data: din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q <= '{ctl: CTL_IDLE, addr: '0, data: '0};
        end else begin
            smp_q <= smp_d;
        end
    end

    pfram_supply_guard #(.REC_CYCLES(REC_CYCLES)) u_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .sup_ok     (smp_q.ctl.sup_ok),
        .batt_low   (smp_q.ctl.batt_low),
        .wr_attempt (wr_attempt),
        .access_ok  (access_ok),
        .block_wr   (block_wr)
    );

    pfram_access_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce_n       (smp_q.ctl.ce_n),
        .we_n       (smp_q.ctl.we_n),
        .oe_n       (smp_q.ctl.oe_n),
        .addr       (smp_q.addr),
        .data       (smp_q.data),
        .access_ok  (access_ok),
        .block_wr   (block_wr),
        .wr_attempt (wr_attempt),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .dout_en    (drive)
    );

    pfram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (smp_q.addr),
        .rd_data (rd_data)
    );

    assign dout_en = drive;
    assign dout    = drive ? rd_data : '0;

    // R6: supply loss stops the drive on the following cycle
    p_off_no_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_q.ctl.sup_ok |=> !dout_en);

    // R6: no array update is issued while the supply is out
    p_off_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_q.ctl.sup_ok |-> !wr_en);

endmodule

// File: tb/test_pfram_top.sv
module test_pfram_top;
    localparam int REC = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [10:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic        dout_en;
    logic        supply_ok = 1'b0;
    logic        batt_low = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    pfram_top #(.REC_CYCLES(REC)) i_pfram_top (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
        .supply_ok(supply_ok), .batt_low(batt_low)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // ce_first=1 closes the window by lifting the select first
    task automatic do_write(input logic [10:0] a, input logic [7:0] d, input bit ce_first);
        @(negedge clk);
        addr = a; din = d; ce_n = 1'b0; we_n = 1'b0;
        wait_n(3);
        if (ce_first) ce_n = 1'b1; else we_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
        wait_n(3);
    endtask

    task automatic do_read(input logic [10:0] a, output logic [7:0] d, output logic en);
        @(negedge clk);
        addr = a; ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0;
        wait_n(3);
        d = dout; en = dout_en;
        ce_n = 1'b1; oe_n = 1'b1;
        wait_n(1);
    endtask

    task automatic read_expect(input string req, input logic [10:0] a, input logic [7:0] exp);
        logic [7:0] d;
        logic       en;
        do_read(a, d, en);
        check(req, {31'd0, en}, 32'd1);
        check(req, {24'd0, d}, {24'd0, exp});
    endtask

    task automatic power_up(input logic bl);
        @(negedge clk);
        batt_low = bl; supply_ok = 1'b1;
        wait_n(5);
        batt_low = 1'b0;
        wait_n(REC + 8);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        logic       en;
        check("R1 reset drive", {31'd0, dout_en}, 32'd0);
        rst_n = 1'b1;
        do_read(11'h010, d, en);
        check("R1 no supply yet", {31'd0, en}, 32'd0);
    endtask

    task automatic t_basic;
        logic [7:0] d;
        logic       en;
        do_write(11'h123, 8'hA5, 1'b0);
        read_expect("R4 we-closed write / R3 read", 11'h123, 8'hA5);
        do_write(11'h7FF, 8'h3C, 1'b1);
        read_expect("R4 ce-closed write", 11'h7FF, 8'h3C);
        do_write(11'h000, 8'hC3, 1'b0);
        read_expect("R4 address zero", 11'h000, 8'hC3);
        read_expect("R4 neighbour untouched", 11'h7FF, 8'h3C);
        // R3: output strobe high keeps drive off
        @(negedge clk);
        addr = 11'h123; ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b1;
        wait_n(3);
        check("R3 oe high", {31'd0, dout_en}, 32'd0);
        ce_n = 1'b1;
        wait_n(1);
        // R2: deselected strobes must not write
        do_write(11'h050, 8'h11, 1'b0);
        @(negedge clk);
        addr = 11'h050; din = 8'hEE; oe_n = 1'b0; we_n = 1'b0;
        wait_n(3);
        check("R2 deselected drive", {31'd0, dout_en}, 32'd0);
        we_n = 1'b1; oe_n = 1'b1;
        wait_n(3);
        do_read(11'h050, d, en);
        check("R2 deselected write ignored", {24'd0, d}, 32'h11);
    endtask

    task automatic t_write_over_read;
        @(negedge clk);
        addr = 11'h123; ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0;
        wait_n(3);
        check("R3 driving before write", {31'd0, dout_en}, 32'd1);
        check("R3 data before write", {24'd0, dout}, 32'hA5);
        din = 8'h5C; we_n = 1'b0;
        wait_n(3);
        check("R5 drive off in write", {31'd0, dout_en}, 32'd0);
        we_n = 1'b1;
        wait_n(3);
        check("R4 write with oe low", {24'd0, dout}, 32'h5C);
        ce_n = 1'b1; oe_n = 1'b1;
        wait_n(2);
    endtask

    task automatic t_supply_loss;
        logic [7:0] d;
        logic       en;
        @(negedge clk);
        supply_ok = 1'b0;
        wait_n(3);
        do_write(11'h123, 8'h00, 1'b0);
        do_read(11'h123, d, en);
        check("R6 no drive when off", {31'd0, en}, 32'd0);
        @(negedge clk);
        supply_ok = 1'b1;
        wait_n(2);
        do_write(11'h050, 8'h99, 1'b0);
        do_read(11'h050, d, en);
        check("R7 no drive in recovery", {31'd0, en}, 32'd0);
        wait_n(REC + 8);
        read_expect("R9 retained / R6 no write when off", 11'h123, 8'h5C);
        read_expect("R7 recovery write ignored", 11'h050, 8'h11);
    endtask

    task automatic t_battery;
        do_write(11'h200, 8'h42, 1'b0);
        @(negedge clk);
        supply_ok = 1'b0;
        wait_n(4);
        power_up(1'b1);
        do_write(11'h200, 8'h77, 1'b0);
        read_expect("R8 first write swallowed", 11'h200, 8'h42);
        do_write(11'h200, 8'h77, 1'b1);
        read_expect("R8 second write lands", 11'h200, 8'h77);
        // R10: battery report while operating is ignored
        @(negedge clk);
        batt_low = 1'b1;
        wait_n(3);
        batt_low = 1'b0;
        do_write(11'h300, 8'h5A, 1'b0);
        read_expect("R10 batt_low ignored while on", 11'h300, 8'h5A);
        // clean return with good battery: first write lands
        @(negedge clk);
        supply_ok = 1'b0;
        wait_n(4);
        power_up(1'b0);
        do_write(11'h301, 8'hB4, 1'b0);
        read_expect("R8 good battery write", 11'h301, 8'hB4);
        read_expect("R9 retained after cycle", 11'h200, 8'h77);
    endtask

    initial begin
        wait_n(3);
        t_reset();
        power_up(1'b0);
        t_basic();
        t_write_over_read();
        t_supply_loss();
        t_battery();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule